// File: doc/BRIEF.md
# DDR2 Refresh and Power-Mode Controller

This block keeps a four-bank DDR2-style memory refreshed and decides when the clock-enable line may go low. A cycle counter measures time against the refresh interval. The interval is derived from two parameters: the clock frequency in MHz and the interval length in nanoseconds. The default interval is 7800 ns. When the interval expires, a refresh becomes pending. It is served by a one-cycle refresh command. If any bank still holds an open row, a one-cycle precharge-all command comes first.

Host requests decide the low-power state. A power-down request gives precharge power-down when every bank is idle. The same request gives active power-down when a row is open. A sleep request with every bank idle gives self-refresh. A read or write in progress (busy) holds the controller where it is. A pending refresh always wins over a low-power request.

Power-down entry and exit, and self-refresh entry, happen on clock edges. Self-refresh exit starts asynchronously: the wake input raises clock-enable at once. The controller then spends a parameterised number of no-op cycles before it returns to normal operation with a fresh refresh interval.

States, as reported on `pstate`:
- ACTIVE = 0
- PRECHARGE_ALL = 1
- REFRESH = 2
- PRECHARGE_PD = 3
- ACTIVE_PD = 4
- SELF_REFRESH = 5
- SR_EXIT = 6

Transitions:
- ACTIVE→PRECHARGE_ALL, when a refresh is due and a row is open.
- ACTIVE→REFRESH, when a refresh is due and all banks are idle.
- PRECHARGE_ALL→REFRESH, always.
- REFRESH→ACTIVE, always.
- ACTIVE→SELF_REFRESH, on a sleep request with all banks idle.
- ACTIVE→PRECHARGE_PD, on a power-down request with all banks idle.
- ACTIVE→ACTIVE_PD, on any low-power request with a row open.
- PRECHARGE_PD/ACTIVE_PD→ACTIVE, when the requests drop or a refresh comes due.
- SELF_REFRESH→SR_EXIT, on wake.
- SR_EXIT→ACTIVE, after the no-op window.

Top module: `refresh_power_ctl`

## Requirements
- R1: While the controller stays in ACTIVE and idle, refresh commands are spaced by exactly REFI = CLK_MHZ*REFI_NS/1000 cycles (integer division). The first refresh becomes due REFI cycles after reset.
- R2: A due refresh with all banks idle moves ACTIVE to REFRESH on the next edge. `ref_cmd` is high for exactly that one cycle, and the state then returns to ACTIVE.
- R3: A due refresh with any bit of `bank_open` set goes through PRECHARGE_ALL first. `pre_all` is high for one cycle, and `ref_cmd` is high in the cycle that follows.
- R4: `pd_req` with all banks idle, no busy and no pending refresh enters PRECHARGE_PD on the next edge. `cke` is 0 in that state.
- R5: `pd_req` or `sr_req` with any bank open, no busy and no pending refresh enters ACTIVE_PD, with `cke` at 0.
- R6: `sr_req` with all banks idle enters SELF_REFRESH with `cke` at 0. No refresh or precharge command is issued while in that state, however long it lasts.
- R7: While `busy` is high in ACTIVE, the state stays ACTIVE, even when a refresh falls due or low-power requests are present.
- R8: Power-down exit is synchronous. From either power-down state, the edge after the requests drop, or after a refresh falls due, returns to ACTIVE with `cke` at 1.
- R9: In SELF_REFRESH, `cke` follows `wake` combinationally. It rises before any clock edge.
- R10: SR_EXIT lasts exactly XSR_CYC cycles with no commands, then goes to ACTIVE. The refresh counter is cleared while in self-refresh and in SR_EXIT. The next refresh command therefore comes REFI+1 cycles after the first ACTIVE cycle.
- R11: A pending refresh takes priority over `pd_req`. It also forces an exit from power-down before the refresh is served.
- R12: During and right after reset, `pstate` = 0 (ACTIVE), `cke` = 1, and `ref_cmd` = `pre_all` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bank_open | input | NBANK | One bit per bank; 1 means a row is open |
| busy | input | 1 | A read or write burst is in progress |
| pd_req | input | 1 | Host requests power-down |
| sr_req | input | 1 | Host requests self-refresh (sleep) |
| wake | input | 1 | Asynchronous self-refresh exit |
| cke | output | 1 | Clock-enable level to the memory |
| ref_cmd | output | 1 | One-cycle auto-refresh command |
| pre_all | output | 1 | One-cycle precharge-all command |
| pstate | output | 3 | Current state, encoded as listed above |

## Verification
The same idle-bank refresh due is driven with banks closed and then with one bank open. This separates the direct refresh path from the precharge-first path. Low-power requests are applied with banks idle, with a bank open, and together with busy. These cases separate the choice between precharge power-down, active power-down and self-refresh, and show that bursts block every move. A refresh is also let fall due while in power-down and while busy, which shows its priority over the requests. A long self-refresh stay followed by a mid-cycle wake checks three things: the asynchronous clock-enable rise, the no-op window length, and the counter restart.

// File: rtl/pm_pkg.sv
package pm_pkg;
    typedef enum logic [2:0] {
        PM_ACTIVE  = 3'd0,
        PM_PREALL  = 3'd1,
        PM_REFRESH = 3'd2,
        PM_PPD     = 3'd3,
        PM_APD     = 3'd4,
        PM_SREF    = 3'd5,
        PM_SRX     = 3'd6
    } pm_state_e;
endpackage

// File: rtl/pm_refi_timer.sv
module pm_refi_timer #(
    parameter int REFI = 1560
) (
    input  logic clk,
    input  logic rst_n,
    input  logic hold,
    input  logic served,
    output logic due
);
    localparam int CW = $clog2(REFI + 1);
    localparam logic [CW-1:0] LAST = CW'(REFI - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
            due <= 1'b0;
        end else if (hold) begin
            cnt <= '0;
            due <= 1'b0;
        end else if (cnt == LAST) begin
            cnt <= '0;
            due <= 1'b1;
        end else begin
            cnt <= cnt + 1'b1;
            if (served)
                due <= 1'b0;
        end
    end
endmodule

// File: rtl/pm_xsr_timer.sv
module pm_xsr_timer #(
    parameter int XSR = 200
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic done
);
    localparam int CW = $clog2(XSR + 1);
    localparam logic [CW-1:0] LAST = CW'(XSR - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= '0;
        else if (run)
            cnt <= cnt + 1'b1;
        else
            cnt <= '0;
    end

    assign done = run && (cnt == LAST);
endmodule

// File: rtl/pm_fsm.sv
module pm_fsm
    import pm_pkg::*;
#(
    parameter int NBANK = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NBANK-1:0] bank_open,
    input  logic             busy,
    input  logic             pd_req,
    input  logic             sr_req,
    input  logic             wake,
    input  logic             due,
    input  logic             xsr_done,
    output pm_state_e        state,
    output logic             cke,
    output logic             ref_cmd,
    output logic             pre_all
);
    pm_state_e state_n;
    logic      any_open;
    logic      lp_req;

    assign any_open = |bank_open;
    assign lp_req   = pd_req | sr_req;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state <= PM_ACTIVE;
        else
            state <= state_n;
    end

    always_comb begin
        state_n = state;
        unique case (state)
            PM_ACTIVE: begin
                if (busy)
                    state_n = PM_ACTIVE;
                else if (due)
                    state_n = any_open ? PM_PREALL : PM_REFRESH;
                else if (sr_req && !any_open)
                    state_n = PM_SREF;
                else if (lp_req)
                    state_n = any_open ? PM_APD : PM_PPD;
            end
            PM_PREALL:  state_n = PM_REFRESH;
            PM_REFRESH: state_n = PM_ACTIVE;
            PM_PPD, PM_APD: begin
                if (due || !lp_req)
                    state_n = PM_ACTIVE;
            end
            PM_SREF: begin
                if (wake)
                    state_n = PM_SRX;
            end
            PM_SRX: begin
                if (xsr_done)
                    state_n = PM_ACTIVE;
            end
            default: state_n = PM_ACTIVE;
        endcase
    end

    always_comb begin
        cke     = 1'b1;
        ref_cmd = 1'b0;
        pre_all = 1'b0;
        unique case (state)
            PM_PREALL:      pre_all = 1'b1;
            PM_REFRESH:     ref_cmd = 1'b1;
            PM_PPD, PM_APD: cke     = 1'b0;
            PM_SREF:        cke     = wake;
            default:        cke     = 1'b1;
        endcase
    end
endmodule

// File: rtl/refresh_power_ctl.sv
module refresh_power_ctl
    import pm_pkg::*;
#(
    parameter int NBANK   = 4,
    parameter int CLK_MHZ = 200,
    parameter int REFI_NS = 7800,
    parameter int XSR_CYC = 200
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NBANK-1:0] bank_open,
    input  logic             busy,
    input  logic             pd_req,
    input  logic             sr_req,
    input  logic             wake,
    output logic             cke,
    output logic             ref_cmd,
    output logic             pre_all,
    output logic [2:0]       pstate
);
    localparam int REFI = (CLK_MHZ * REFI_NS) / 1000;

    pm_state_e state;
    logic      due;
    logic      xsr_done;
    logic      in_sleep;
    logic      in_exit;

    assign in_exit  = (state == PM_SRX);
    assign in_sleep = (state == PM_SREF) || in_exit;
    assign pstate   = state;

    pm_refi_timer #(.REFI(REFI)) u_refi (
        .clk    (clk),
        .rst_n  (rst_n),
        .hold   (in_sleep),
        .served (ref_cmd),
        .due    (due)
    );

    pm_xsr_timer #(.XSR(XSR_CYC)) u_xsr (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (in_exit),
        .done  (xsr_done)
    );

    pm_fsm #(.NBANK(NBANK)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .bank_open (bank_open),
        .busy      (busy),
        .pd_req    (pd_req),
        .sr_req    (sr_req),
        .wake      (wake),
        .due       (due),
        .xsr_done  (xsr_done),
        .state     (state),
        .cke       (cke),
        .ref_cmd   (ref_cmd),
        .pre_all   (pre_all)
    );
endmodule

// File: rtl/pm_chk.sv
module pm_chk
    import pm_pkg::*;
#(
    parameter int NBANK = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic [NBANK-1:0] bank_open,
    input logic             busy,
    input logic             cke,
    input logic             ref_cmd,
    input logic             pre_all,
    input logic [2:0]       pstate
);
    // R7
    busy_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pstate == PM_ACTIVE && busy) |=> (pstate == PM_ACTIVE));

    // R3
    prechg_then_ref_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pre_all |=> ref_cmd);

    // R2
    ref_after_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ref_cmd |-> ($past(pre_all) || ($past(bank_open) == '0)));

    // R6
    sref_entry_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pstate == PM_SREF) |-> ($past(bank_open) == '0));

    // R10
    sref_leaves_via_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pstate == PM_SREF) |=> (pstate == PM_SREF || pstate == PM_SRX));

    // R4
    cke_low_only_lp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cke |-> (pstate == PM_PPD || pstate == PM_APD || pstate == PM_SREF));

    // R12
    one_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({ref_cmd, pre_all}));
endmodule

bind refresh_power_ctl pm_chk #(.NBANK(NBANK)) u_pm_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bank_open (bank_open),
    .busy      (busy),
    .cke       (cke),
    .ref_cmd   (ref_cmd),
    .pre_all   (pre_all),
    .pstate    (pstate)
);

// File: tb/tb_refresh_power_ctl.sv
`timescale 1ns/1ps
module tb_refresh_power_ctl;
    localparam int REFI = 40;
    localparam int XSR  = 5;
    localparam int S_ACT = 0, S_PRE = 1, S_REF = 2, S_PPD = 3,
                   S_APD = 4, S_SR = 5, S_SRX = 6;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] bank_open = '0;
    logic       busy = 1'b0, pd_req = 1'b0, sr_req = 1'b0, wake = 1'b0;
    logic       cke, ref_cmd, pre_all;
    logic [2:0] pstate;

    int vectors = 0;
    int miscmp  = 0;

    always #2.5 clk = ~clk;

    refresh_power_ctl #(.NBANK(4), .CLK_MHZ(200), .REFI_NS(200), .XSR_CYC(XSR)) dut (
        .clk(clk), .rst_n(rst_n), .bank_open(bank_open), .busy(busy),
        .pd_req(pd_req), .sr_req(sr_req), .wake(wake),
        .cke(cke), .ref_cmd(ref_cmd), .pre_all(pre_all), .pstate(pstate)
    );

    // behavioural reference
    int m_st = S_ACT, m_cnt = 0, m_x = 0, nst = 0;
    bit m_due = 0, any_o = 0, lp = 0;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_st = S_ACT; m_cnt = 0; m_x = 0; m_due = 0;
        end else begin
            any_o = |bank_open;
            lp = pd_req || sr_req;
            nst = m_st;
            case (m_st)
                S_ACT: if (!busy) begin
                    if (m_due) nst = any_o ? S_PRE : S_REF;
                    else if (sr_req && !any_o) nst = S_SR;
                    else if (lp) nst = any_o ? S_APD : S_PPD;
                end
                S_PRE: nst = S_REF;
                S_REF: nst = S_ACT;
                S_PPD, S_APD: if (m_due || !lp) nst = S_ACT;
                S_SR:  if (wake) nst = S_SRX;
                S_SRX: if (m_x == XSR - 1) nst = S_ACT;
                default: nst = S_ACT;
            endcase
            if (m_st == S_SR || m_st == S_SRX) begin
                m_cnt = 0; m_due = 0;
            end else begin
                if (m_st == S_REF) m_due = 0;
                if (m_cnt == REFI - 1) begin m_cnt = 0; m_due = 1; end
                else m_cnt++;
            end
            m_x = (m_st == S_SRX) ? m_x + 1 : 0;
            m_st = nst;
        end
    end

    function automatic string tag_of(int s);
        case (s)
            S_PRE:   return "R3";
            S_REF:   return "R2";
            S_PPD:   return "R4";
            S_APD:   return "R5";
            S_SR:    return "R6";
            S_SRX:   return "R10";
            default: return "R8";
        endcase
    endfunction

    task automatic chk(bit ok, string req, int act, int exp);
        vectors++;
        if (!ok) begin
            miscmp++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic compare();
        int e_cke;
        e_cke = (m_st == S_PPD || m_st == S_APD) ? 0 : (m_st == S_SR) ? int'(wake) : 1;
        chk(int'(pstate) == m_st, {tag_of(m_st), " state"}, pstate, m_st);
        chk(int'(cke) == e_cke, {tag_of(m_st), " cke"}, cke, e_cke);
        chk(int'(ref_cmd) == int'(m_st == S_REF), {tag_of(m_st), " ref_cmd"}, ref_cmd, m_st == S_REF);
        chk(int'(pre_all) == int'(m_st == S_PRE), {tag_of(m_st), " pre_all"}, pre_all, m_st == S_PRE);
    endtask

    task automatic step(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            compare();
        end
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscmp);
    endtask

    initial begin
        #(5.0 * 40000);
        miscmp++;
        $display("FAIL watchdog actual=timeout expected=finish");
        summary();
        $finish;
    end

    initial begin
        int t, refs;
        repeat (3) @(negedge clk);
        // R12 reset state
        chk(pstate == 3'd0 && cke && !ref_cmd && !pre_all, "R12 reset", pstate, 0);
        rst_n = 1'b1;
        step(1);
        chk(pstate == 3'd0 && cke, "R12 after reset", pstate, 0);

        // R1 spacing of idle refreshes
        t = 0;
        while (!ref_cmd && t < 100) begin step(1); t++; end
        t = 0;
        do begin step(1); t++; end while (!ref_cmd && t < 100);
        chk(t == REFI, "R1 refresh spacing", t, REFI);
        step(1);
        chk(pstate == 3'd0, "R2 back to active", pstate, S_ACT);

        // R3 precharge first with an open bank
        bank_open = 4'b0100;
        t = 0;
        while (!pre_all && t < 100) begin step(1); t++; end
        step(1);
        chk(ref_cmd == 1'b1, "R3 ref after pre_all", ref_cmd, 1);
        bank_open = '0;
        step(2);

        // R4 precharge power-down
        pd_req = 1'b1;
        step(1);
        chk(pstate == S_PPD && !cke, "R4 enter PPD", pstate, S_PPD);
        // R11 refresh due forces exit then refresh
        t = 0;
        while (pstate != S_ACT && t < 100) begin step(1); t++; end
        chk(cke == 1'b1, "R8 exit on due", cke, 1);
        step(1);
        chk(ref_cmd == 1'b1, "R11 refresh beats pd_req", ref_cmd, 1);
        step(2);
        chk(pstate == S_PPD, "R4 re-enter PPD", pstate, S_PPD);
        pd_req = 1'b0;
        step(1);
        chk(pstate == S_ACT && cke, "R8 sync exit", pstate, S_ACT);

        // R5 active power-down
        bank_open = 4'b0001;
        pd_req = 1'b1;
        step(1);
        chk(pstate == S_APD && !cke, "R5 enter APD", pstate, S_APD);
        pd_req = 1'b0;
        step(1);
        sr_req = 1'b1;
        step(1);
        chk(pstate == S_APD, "R5 sleep with open row", pstate, S_APD);
        sr_req = 1'b0;
        bank_open = '0;
        step(2);

        // R7 busy blocks everything
        busy = 1'b1;
        pd_req = 1'b1;
        refs = 0;
        for (int i = 0; i < 50; i++) begin
            step(1);
            if (ref_cmd || pstate != S_ACT) refs++;
        end
        chk(refs == 0, "R7 busy holds active", refs, 0);
        busy = 1'b0;
        step(1);
        chk(ref_cmd == 1'b1, "R11 pending refresh first", ref_cmd, 1);
        pd_req = 1'b0;
        step(2);

        // R6 self-refresh
        sr_req = 1'b1;
        step(1);
        chk(pstate == S_SR && !cke, "R6 enter self-refresh", pstate, S_SR);
        refs = 0;
        for (int i = 0; i < 100; i++) begin
            step(1);
            if (ref_cmd || pre_all) refs++;
        end
        chk(refs == 0, "R6 no commands asleep", refs, 0);
        // R9 asynchronous wake
        wake = 1'b1;
        #1;
        chk(cke == 1'b1, "R9 cke rises on wake", cke, 1);
        step(1);
        sr_req = 1'b0;
        wake = 1'b0;
        chk(pstate == S_SRX, "R10 exit window start", pstate, S_SRX);
        step(XSR - 1);
        chk(pstate == S_SRX, "R10 exit window end", pstate, S_SRX);
        step(1);
        chk(pstate == S_ACT, "R10 back to active", pstate, S_ACT);
        t = 0;
        do begin step(1); t++; end while (!ref_cmd && t < 100);
        chk(t == REFI + 1, "R10 counter restarted", t, REFI + 1);

        step(5);
        summary();
        $finish;
    end
endmodule